// File: doc/BRIEF.md
# Interrupt Message Destination Filter

This block sits inside the local interrupt controller of one processor. Every interrupt message on the shared message bus goes to the filters of all processors. Each filter decides on its own whether its processor takes the message. A message carries four things: an 8-bit destination, a mode bit that selects physical or logical addressing, a 3-bit delivery type and an 8-bit vector. Because the vector travels with the message, an accepted vectored interrupt needs no later fetch cycle.

The filter holds two programmable identities. The physical ID takes a default value at reset, and a register write port can rewrite it later. The logical ID names the groups this unit belongs to and is written through the same port. A physical-mode message matches when its destination equals the physical ID, or when it is the broadcast code. A logical-mode message matches when its destination mask shares at least one set bit with the logical ID. Fixed and lowest-priority messages that are accepted leave the block as a vector-valid pulse with the vector. NMI, SMI and INIT messages leave on their own one-cycle strobes. Arbitration for lowest-priority delivery is done elsewhere, and its result comes in as a single win flag.

Top module: `irq_dest_filter`

## Requirements
- R1: After reset, vec_valid, nmi_strobe, smi_strobe and init_strobe are 0, vec_out is 0, phys_id equals parameter PHYS_ID_RST (default 8'h03) and logical_id equals parameter LOGICAL_ID_RST (default 8'h00).
- R2: A message with msg_valid=1 and msg_logical=0 matches when msg_dest equals the current phys_id.
- R3: A message with msg_logical=0 and msg_dest=8'hFF is a broadcast and matches whatever the value of phys_id.
- R4: A message with msg_logical=1 matches when (msg_dest & logical_id) is nonzero. If the AND is zero, the message causes no output.
- R5: A matching message of delivery type fixed (msg_dtype=3'b000) raises vec_valid for exactly one cycle, on the clock edge after the edge that sampled the message, with vec_out equal to msg_vector.
- R6: A matching message of type lowest-priority (3'b001) produces the R5 vector pulse only when arb_win is 1 in the same cycle as msg_valid. Otherwise it produces nothing.
- R7: A matching message of type SMI (3'b010), NMI (3'b100) or INIT (3'b101) raises only smi_strobe, nmi_strobe or init_strobe respectively, for one cycle with the R5 timing, and leaves vec_valid at 0.
- R8: Reserved types 3'b011, 3'b110 and 3'b111 produce no output even when the destination matches.
- R9: When id_wr_en=1, id_wr_data is written to phys_id if id_wr_sel=0 and to logical_id if id_wr_sel=1. The new value appears on the next cycle. A message sampled in the same cycle as the write is matched against the old value.
- R10: At most one of vec_valid, nmi_strobe, smi_strobe, init_strobe is high in any cycle. None is high unless msg_valid was high on the previous cycle. vec_out is 0 whenever vec_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A message is present this cycle |
| msg_dest | input | 8 | Destination ID or logical mask |
| msg_logical | input | 1 | 1 = logical addressing, 0 = physical |
| msg_dtype | input | 3 | Delivery type |
| msg_vector | input | 8 | Interrupt vector |
| arb_win | input | 1 | This unit won lowest-priority arbitration |
| id_wr_en | input | 1 | ID register write strobe |
| id_wr_sel | input | 1 | 0 = physical ID, 1 = logical ID |
| id_wr_data | input | 8 | Value to write |
| vec_valid | output | 1 | One-cycle vectored interrupt pulse |
| vec_out | output | 8 | Vector that goes with vec_valid |
| nmi_strobe | output | 1 | One-cycle NMI strobe |
| smi_strobe | output | 1 | One-cycle SMI strobe |
| init_strobe | output | 1 | One-cycle INIT strobe |
| phys_id | output | 8 | Current physical ID |
| logical_id | output | 8 | Current logical ID |

## Verification
The assertions check on every cycle that the four outputs are mutually exclusive, that no output fires without a message on the previous cycle, and that vec_out is zero while vec_valid is low. They also check that physical and broadcast hits of fixed type yield the vector one edge later, that a losing lowest-priority message stays silent, that a special-type hit raises its strobe, and that ID writes land. Only the bench scenarios can show the whole accept and reject decision against an independent model: logical masks that overlap partly or not at all, reserved types, a write and a message in the same cycle, and IDs reprogrammed between random messages.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

  // Delivery type encoding carried in the message
  typedef enum logic [2:0] {
    DT_FIXED  = 3'b000,
    DT_LOWPRI = 3'b001,
    DT_SMI    = 3'b010,
    DT_RSV3   = 3'b011,
    DT_NMI    = 3'b100,
    DT_INIT   = 3'b101,
    DT_RSV6   = 3'b110,
    DT_RSV7   = 3'b111
  } dtype_e;

  // Output selected for an accepted message
  typedef enum logic [2:0] {
    RT_NONE,
    RT_VEC,
    RT_NMI,
    RT_SMI,
    RT_INIT
  } route_e;

  localparam int DTYPE_W = 3;

endpackage

// File: rtl/irqf_id_regs.sv
module irqf_id_regs #(
  parameter int               ID_W     = 8,
  parameter logic [ID_W-1:0]  PHYS_RST = '0,
  parameter logic [ID_W-1:0]  LOG_RST  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [ID_W-1:0] wr_data,
  output logic [ID_W-1:0] phys_q,
  output logic [ID_W-1:0] log_q
);

  logic wr_phys;
  logic wr_log;

  assign wr_phys = wr_en && !wr_sel;
  assign wr_log  = wr_en &&  wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phys_q <= PHYS_RST;
      log_q  <= LOG_RST;
    end else begin
      if (wr_phys) phys_q <= wr_data;
      if (wr_log)  log_q  <= wr_data;
    end
  end

endmodule

// File: rtl/irqf_match.sv
module irqf_match #(
  parameter int ID_W     = 8,
  parameter bit BCAST_EN = 1'b1
) (
  input  logic            logical,
  input  logic [ID_W-1:0] dest,
  input  logic [ID_W-1:0] phys_id,
  input  logic [ID_W-1:0] log_id,
  output logic            hit,
  output logic            is_bcast
);

  localparam logic [ID_W-1:0] BCAST_CODE = {ID_W{1'b1}};

  function automatic logic phys_equal(input logic [ID_W-1:0] d,
                                      input logic [ID_W-1:0] id);
    return d == id;
  endfunction

  function automatic logic group_overlap(input logic [ID_W-1:0] mask,
                                         input logic [ID_W-1:0] id);
    return |(mask & id);
  endfunction

  logic bcast_w;

  generate
    if (BCAST_EN) begin : g_bcast
      assign bcast_w = !logical && (dest == BCAST_CODE);
    end else begin : g_nobcast
      assign bcast_w = 1'b0;
    end
  endgenerate

  logic phys_hit_w;
  logic log_hit_w;

  assign phys_hit_w = !logical && (phys_equal(dest, phys_id) || bcast_w);
  assign log_hit_w  =  logical && group_overlap(dest, log_id);
  assign hit        = phys_hit_w || log_hit_w;
  assign is_bcast   = bcast_w;

endmodule

// File: rtl/irqf_route.sv
module irqf_route
  import irqf_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic               hit,
  input  logic [DTYPE_W-1:0] dtype,
  input  logic               arb_win,
  input  logic [VEC_W-1:0]   vector,
  output route_e             sel,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_out,
  output logic               nmi_strobe,
  output logic               smi_strobe,
  output logic               init_strobe
);

  function automatic route_e classify(input logic [DTYPE_W-1:0] t,
                                      input logic win);
    route_e r;
    case (dtype_e'(t))
      DT_FIXED:  r = RT_VEC;
      DT_LOWPRI: r = win ? RT_VEC : RT_NONE;
      DT_NMI:    r = RT_NMI;
      DT_SMI:    r = RT_SMI;
      DT_INIT:   r = RT_INIT;
      default:   r = RT_NONE;
    endcase
    return r;
  endfunction

  always_comb begin
    sel = RT_NONE;
    if (valid && hit) sel = classify(dtype, arb_win);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid   <= 1'b0;
      vec_out     <= '0;
      nmi_strobe  <= 1'b0;
      smi_strobe  <= 1'b0;
      init_strobe <= 1'b0;
    end else begin
      vec_valid   <= (sel == RT_VEC);
      vec_out     <= (sel == RT_VEC) ? vector : '0;
      nmi_strobe  <= (sel == RT_NMI);
      smi_strobe  <= (sel == RT_SMI);
      init_strobe <= (sel == RT_INIT);
    end
  end

endmodule

// File: rtl/irq_dest_filter.sv
module irq_dest_filter
  import irqf_pkg::*;
#(
  parameter int              ID_W           = 8,
  parameter int              VEC_W          = 8,
  parameter logic [ID_W-1:0] PHYS_ID_RST    = 8'h03,
  parameter logic [ID_W-1:0] LOGICAL_ID_RST = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  logic [ID_W-1:0]    msg_dest,
  input  logic               msg_logical,
  input  logic [DTYPE_W-1:0] msg_dtype,
  input  logic [VEC_W-1:0]   msg_vector,
  input  logic               arb_win,
  input  logic               id_wr_en,
  input  logic               id_wr_sel,
  input  logic [ID_W-1:0]    id_wr_data,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_out,
  output logic               nmi_strobe,
  output logic               smi_strobe,
  output logic               init_strobe,
  output logic [ID_W-1:0]    phys_id,
  output logic [ID_W-1:0]    logical_id
);

  // Named internal events, visible to the bound checker
  logic   msg_hit;
  logic   msg_bcast;
  route_e route_sel;

  irqf_id_regs #(
    .ID_W     (ID_W),
    .PHYS_RST (PHYS_ID_RST),
    .LOG_RST  (LOGICAL_ID_RST)
  ) u_ids (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (id_wr_en),
    .wr_sel  (id_wr_sel),
    .wr_data (id_wr_data),
    .phys_q  (phys_id),
    .log_q   (logical_id)
  );

  irqf_match #(
    .ID_W     (ID_W),
    .BCAST_EN (1'b1)
  ) u_match (
    .logical  (msg_logical),
    .dest     (msg_dest),
    .phys_id  (phys_id),
    .log_id   (logical_id),
    .hit      (msg_hit),
    .is_bcast (msg_bcast)
  );

  irqf_route #(
    .VEC_W (VEC_W)
  ) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (msg_valid),
    .hit         (msg_hit),
    .dtype       (msg_dtype),
    .arb_win     (arb_win),
    .vector      (msg_vector),
    .sel         (route_sel),
    .vec_valid   (vec_valid),
    .vec_out     (vec_out),
    .nmi_strobe  (nmi_strobe),
    .smi_strobe  (smi_strobe),
    .init_strobe (init_strobe)
  );

endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
  import irqf_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int VEC_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic [ID_W-1:0]    msg_dest,
  input logic               msg_logical,
  input logic [DTYPE_W-1:0] msg_dtype,
  input logic [VEC_W-1:0]   msg_vector,
  input logic               arb_win,
  input logic               id_wr_en,
  input logic               id_wr_sel,
  input logic [ID_W-1:0]    id_wr_data,
  input logic               vec_valid,
  input logic [VEC_W-1:0]   vec_out,
  input logic               nmi_strobe,
  input logic               smi_strobe,
  input logic               init_strobe,
  input logic [ID_W-1:0]    phys_id,
  input logic [ID_W-1:0]    logical_id,
  input logic               msg_hit,
  input logic               msg_bcast
);

  logic any_out;
  assign any_out = vec_valid | nmi_strobe | smi_strobe | init_strobe;

  a_r10_one_output: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_valid, nmi_strobe, smi_strobe, init_strobe}));

  a_r10_needs_msg: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> $past(msg_valid));

  a_r10_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> vec_out == '0);

  a_r2_phys_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_logical && msg_dest == phys_id && msg_dtype == 3'b000)
    |=> (vec_valid && vec_out == $past(msg_vector)));

  a_r3_bcast_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_bcast && msg_dtype == 3'b000)
    |=> (vec_valid && vec_out == $past(msg_vector)));

  a_r6_loser_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_dtype == 3'b001 && !arb_win) |=> !vec_valid);

  a_r7_nmi_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_hit && msg_dtype == 3'b100) |=> (nmi_strobe && !vec_valid));

  a_r4_log_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_logical && ((msg_dest & logical_id) == '0)) |=> !any_out);

  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_dtype == 3'b011 || msg_dtype[2:1] == 2'b11)) |=> !any_out);

  a_r9_phys_write: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr_en && !id_wr_sel) |=> phys_id == $past(id_wr_data));

  a_r9_log_write: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr_en && id_wr_sel) |=> logical_id == $past(id_wr_data));

endmodule

bind irq_dest_filter irqf_checker #(
  .ID_W  (ID_W),
  .VEC_W (VEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_dest    (msg_dest),
  .msg_logical (msg_logical),
  .msg_dtype   (msg_dtype),
  .msg_vector  (msg_vector),
  .arb_win     (arb_win),
  .id_wr_en    (id_wr_en),
  .id_wr_sel   (id_wr_sel),
  .id_wr_data  (id_wr_data),
  .vec_valid   (vec_valid),
  .vec_out     (vec_out),
  .nmi_strobe  (nmi_strobe),
  .smi_strobe  (smi_strobe),
  .init_strobe (init_strobe),
  .phys_id     (phys_id),
  .logical_id  (logical_id),
  .msg_hit     (msg_hit),
  .msg_bcast   (msg_bcast)
);

// File: tb/sim_irq_dest_filter.sv
`timescale 1ns/100ps
module sim_irq_dest_filter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       msg_valid;
  logic [7:0] msg_dest;
  logic       msg_logical;
  logic [2:0] msg_dtype;
  logic [7:0] msg_vector;
  logic       arb_win;
  logic       id_wr_en;
  logic       id_wr_sel;
  logic [7:0] id_wr_data;
  logic       vec_valid;
  logic [7:0] vec_out;
  logic       nmi_strobe, smi_strobe, init_strobe;
  logic [7:0] phys_id, logical_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_phys;
  logic [7:0] m_log;

  always #2.5 clk = ~clk;

  irq_dest_filter u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_dest(msg_dest),
    .msg_logical(msg_logical), .msg_dtype(msg_dtype), .msg_vector(msg_vector),
    .arb_win(arb_win), .id_wr_en(id_wr_en), .id_wr_sel(id_wr_sel),
    .id_wr_data(id_wr_data), .vec_valid(vec_valid), .vec_out(vec_out),
    .nmi_strobe(nmi_strobe), .smi_strobe(smi_strobe), .init_strobe(init_strobe),
    .phys_id(phys_id), .logical_id(logical_id)
  );

  // Expected {vec_valid, nmi, smi, init} from the requirements
  function automatic logic [3:0] want_out(logic [7:0] d, logic lg, logic [2:0] t,
                                          logic win, logic [7:0] p, logic [7:0] l);
    logic m;
    if (lg) m = (d & l) != 8'h00;              // R4
    else    m = (d == p) || (d == 8'hFF);      // R2, R3
    if (!m) return 4'b0000;
    case (t)
      3'b000:  return 4'b1000;                 // R5
      3'b001:  return win ? 4'b1000 : 4'b0000; // R6
      3'b100:  return 4'b0100;                 // R7 NMI
      3'b010:  return 4'b0010;                 // R7 SMI
      3'b101:  return 4'b0001;                 // R7 INIT
      default: return 4'b0000;                 // R8
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    msg_valid = 0; msg_dest = 0; msg_logical = 0; msg_dtype = 0;
    msg_vector = 0; arb_win = 0; id_wr_en = 0; id_wr_sel = 0; id_wr_data = 0;
  endtask

  // Drive one message (and optional ID write) at a negedge, check at the next.
  task automatic send(string tag, logic [7:0] d, logic lg, logic [2:0] t,
                      logic [7:0] v, logic win, logic we, logic ws, logic [7:0] wd);
    logic [3:0] e;
    @(negedge clk);
    msg_valid = 1; msg_dest = d; msg_logical = lg; msg_dtype = t;
    msg_vector = v; arb_win = win; id_wr_en = we; id_wr_sel = ws; id_wr_data = wd;
    e = want_out(d, lg, t, win, m_phys, m_log);   // old IDs (R9)
    if (we) begin
      if (ws) m_log = wd; else m_phys = wd;
    end
    @(negedge clk);
    idle();
    chk({tag, " outputs"}, {28'd0, vec_valid, nmi_strobe, smi_strobe, init_strobe},
        {28'd0, e});
    chk({tag, " vec_out"}, {24'd0, vec_out}, {24'd0, e[3] ? v : 8'h00});
    chk("R9 phys_id", {24'd0, phys_id}, {24'd0, m_phys});
    chk("R9 logical_id", {24'd0, logical_id}, {24'd0, m_log});
    @(negedge clk);
    chk("R10 strobe width", {28'd0, vec_valid, nmi_strobe, smi_strobe, init_strobe},
        32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    m_phys = 8'h03;
    m_log  = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 outputs", {28'd0, vec_valid, nmi_strobe, smi_strobe, init_strobe}, 32'd0);
    chk("R1 vec_out", {24'd0, vec_out}, 32'd0);
    chk("R1 phys_id", {24'd0, phys_id}, 32'h03);
    chk("R1 logical_id", {24'd0, logical_id}, 32'h00);

    // Directed corner cases
    send("R2 phys hit", 8'h03, 0, 3'b000, 8'h41, 0, 0, 0, 0);
    send("R2 phys miss", 8'h04, 0, 3'b000, 8'h42, 0, 0, 0, 0);
    send("R3 broadcast", 8'hFF, 0, 3'b000, 8'h43, 0, 0, 0, 0);
    send("R4 log zero id", 8'hFF, 1, 3'b000, 8'h44, 0, 0, 0, 0);
    send("R9 write log", 8'h00, 0, 3'b000, 8'h00, 0, 1, 1, 8'h0A);
    send("R4 log overlap", 8'h02, 1, 3'b000, 8'h45, 0, 0, 0, 0);
    send("R4 log disjoint", 8'h05, 1, 3'b000, 8'h46, 0, 0, 0, 0);
    send("R6 lowpri win", 8'h03, 0, 3'b001, 8'h47, 1, 0, 0, 0);
    send("R6 lowpri lose", 8'h03, 0, 3'b001, 8'h48, 0, 0, 0, 0);
    send("R7 nmi", 8'h03, 0, 3'b100, 8'h49, 0, 0, 0, 0);
    send("R7 smi", 8'h08, 1, 3'b010, 8'h4A, 0, 0, 0, 0);
    send("R7 init", 8'hFF, 0, 3'b101, 8'h4B, 0, 0, 0, 0);
    send("R8 rsv3", 8'h03, 0, 3'b011, 8'h4C, 1, 0, 0, 0);
    send("R8 rsv6", 8'h03, 0, 3'b110, 8'h4D, 1, 0, 0, 0);
    send("R8 rsv7", 8'h03, 0, 3'b111, 8'h4E, 1, 0, 0, 0);
    send("R9 same-cycle old id", 8'h03, 0, 3'b000, 8'h4F, 0, 1, 0, 8'h21);
    send("R9 new id hit", 8'h21, 0, 3'b000, 8'h50, 0, 0, 0, 0);
    send("R9 old id miss", 8'h03, 0, 3'b000, 8'h51, 0, 0, 0, 0);

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] d;
      logic [2:0] sel;
      logic lg;
      sel = 3'($urandom_range(0, 5));
      lg  = 1'($urandom_range(0, 1));
      case (sel)
        3'd0: d = m_phys;
        3'd1: d = 8'hFF;
        3'd2: d = m_log;
        default: d = 8'($urandom);
      endcase
      send("R5 random", d, lg, 3'($urandom), 8'($urandom), 1'($urandom),
           $urandom_range(0, 9) == 0, 1'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule